// File: doc/BRIEF.md
# Memory Access Rights Checker

This block sits on the path from three bus masters (the processor, a DMA engine and a debug port) to memory. Each access carries a 16-bit address, a master code and an access kind. The block places the address in one of three main-memory segments. The segments are split by two boundary inputs. The block also flags the address when it falls inside an isolated-IP window, and when it falls inside the fixed vector window at 0xFF80 to 0xFFFF. It then grants or refuses the access in the same cycle. Memory strobes leave the block only for granted accesses.

The vector window has special rights. Reads of it always succeed. Writes to it follow the enclosing segment's write bit while segment checking is on. Processor fetches from it are refused only when the isolated-IP window covers the address. Addresses next to the window, such as a handler placed just below it, get no such relief.

A refused access sets a sticky fault bit for its segment. Software clears these bits by writing ones to them. One clock edge later, the block emits a single-cycle pulse. The pulse is either a non-maskable interrupt or a soft-reset request, as chosen by that segment's select bit. Read data seen by the master is replaced with 0x3FFF from the cycle after the refusal until the data of the next granted read or fetch arrives.

Top module: `mem_rights_chk`

## Requirements
- R1: The segment is 0 when the address is below `bnd_lo`, 2 when the address is at or above `bnd_hi`, and 1 otherwise. With `mpu_en`=1, a read, write or fetch outside the vector window needs bit 0, 1 or 2 of `seg_perm[3s+2:3s]` for its segment s.
- R2: With `mpu_en`=0, the segment permission bits restrict nothing.
- R3: Outside the vector window, an address inside the enabled isolated-IP window (`ip_lo` to `ip_hi`, both inclusive) is refused to DMA (master code 1) and debug (master code 2). The processor (master code 0) is still subject to R1.
- R4: A read (kind 0) of any address from 0xFF80 to 0xFFFF is granted to all three masters, whatever the segment read bits are.
- R5: A write (kind 1) inside the vector window is granted when `mpu_en`=0. Otherwise it follows the segment write bit. The isolated-IP window does not affect it.
- R6: A fetch (kind 2) inside the vector window is refused when the isolated-IP window covers the address and granted otherwise. The segment execute bit is ignored there.
- R7: A fetch at 0xFF7F, just below the window, is judged by the segment execute bit.
- R8: A refused access raises neither `mem_wr_en` nor `mem_rd_en`. Master code 3 and kind 3 are always refused.
- R9: After a refusal, exactly one of `nmi_pulse` and `rst_req` is high for the single cycle that follows. `rst_req` is chosen when `vsel[s]`=1, and `nmi_pulse` when `vsel[s]`=0.
- R10: `rdata_out` is 0x3FFF from the cycle after a refusal until the cycle after the next granted read or fetch. At all other times it equals `mem_rdata`.
- R11: `viol_flags[s]` is set by a refusal in segment s and stays set until a 1 is written to `flag_clr[s]`. A refusal in the same cycle as the clear wins.
- R12: After reset, the pulses are low, the flags are zero and `rdata_out` follows `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_master | input | 2 | 0 processor, 1 DMA, 2 debug, 3 reserved |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_addr | input | 16 | Access address |
| mpu_en | input | 1 | Segment permission checking on |
| bnd_lo | input | 16 | First segment boundary |
| bnd_hi | input | 16 | Second segment boundary |
| seg_perm | input | 9 | Per segment {exec, write, read} |
| vsel | input | 3 | Per segment response: 0 interrupt, 1 reset |
| ip_en | input | 1 | Isolated-IP window on |
| ip_lo | input | 16 | First address of isolated-IP window |
| ip_hi | input | 16 | Last address of isolated-IP window |
| flag_clr | input | 3 | Write-1-to-clear of fault flags |
| mem_rdata | input | 16 | Read data from memory |
| acc_grant | output | 1 | Access granted |
| mem_wr_en | output | 1 | Write strobe to memory |
| mem_rd_en | output | 1 | Read/fetch strobe to memory |
| rdata_out | output | 16 | Read data to the master |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |
| rst_req | output | 1 | Soft reset request pulse |
| viol_flags | output | 3 | Sticky per-segment fault flags |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 16-bit data path, a window base of 0xFF80 and a fill of 0x3FFF. These defaults put both segment boundaries, both edges of the isolated-IP window and the first and last window addresses within reach of directed vectors. The bench then moves the isolated-IP window over the vector window and turns segment checking off. This covers all three overlap cases of the window, together with the timing of the pulses and the substituted data.

// File: rtl/mrc_pkg.sv
// Shared encodings for the memory access rights checker.
// Assumes a two-bit master code and a two-bit access kind code.
package mrc_pkg;
    localparam int NSEG = 3;
    localparam int SEGW = 2;

    typedef enum logic [1:0] {
        M_CPU  = 2'd0,
        M_DMA  = 2'd1,
        M_DBG  = 2'd2,
        M_RSVD = 2'd3
    } master_e;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_FETCH = 2'd2,
        K_RSVD  = 2'd3
    } kind_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;
endpackage

// File: rtl/mrc_region_dec.sv
// Address classifier: picks the segment from two boundaries, and flags the
// vector window and the isolated-IP window. Assumes bnd_lo <= bnd_hi.
module mrc_region_dec
    import mrc_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [15:0] VEC_BASE = 16'hFF80
) (
    input  logic [AW-1:0]   addr,
    input  logic [AW-1:0]   bnd_lo,
    input  logic [AW-1:0]   bnd_hi,
    input  logic            ip_en,
    input  logic [AW-1:0]   ip_lo,
    input  logic [AW-1:0]   ip_hi,
    output logic [SEGW-1:0] seg_idx,
    output logic            in_win,
    output logic            in_ip
);
    localparam logic [AW-1:0] WIN_LO = AW'(VEC_BASE);

    // Segment index from the two boundaries
    always_comb begin
        if (addr < bnd_lo)       seg_idx = 2'd0;
        else if (addr >= bnd_hi) seg_idx = 2'd2;
        else                     seg_idx = 2'd1;
    end

    // Window membership flags
    always_comb begin
        in_win = (addr >= WIN_LO);
        in_ip  = ip_en && (addr >= ip_lo) && (addr <= ip_hi);
    end
endmodule

// File: rtl/mrc_rights.sv
// Combinational rights evaluation for one access. Applies the vector window
// override, then the isolated-IP master restriction, then segment bits.
module mrc_rights
    import mrc_pkg::*;
(
    input  logic [1:0]        master,
    input  logic [1:0]        kind,
    input  logic [SEGW-1:0]   seg_idx,
    input  logic              in_win,
    input  logic              in_ip,
    input  logic              mpu_en,
    input  logic [3*NSEG-1:0] seg_perm,
    output logic              allow
);
    perm_t perm_arr [NSEG];
    perm_t cur;
    logic  ok_r, ok_w, ok_x, legal, seg_ok;

    // Unpack the per-segment permission triples
    for (genvar s = 0; s < NSEG; s++) begin : g_perm
        assign perm_arr[s] = perm_t'(seg_perm[3*s +: 3]);
    end

    // Select permissions of the addressed segment
    always_comb begin
        cur = perm_arr[0];
        for (int s = 1; s < NSEG; s++)
            if (seg_idx == SEGW'(s)) cur = perm_arr[s];
    end

    // Effective segment rights with checking possibly off
    always_comb begin
        ok_r  = !mpu_en || cur.r;
        ok_w  = !mpu_en || cur.w;
        ok_x  = !mpu_en || cur.x;
        legal = (master != M_RSVD) && (kind != K_RSVD);
        case (kind)
            K_READ:  seg_ok = ok_r;
            K_WRITE: seg_ok = ok_w;
            K_FETCH: seg_ok = ok_x;
            default: seg_ok = 1'b0;
        endcase
    end

    // Final decision
    always_comb begin
        if (!legal) begin
            allow = 1'b0;
        end else if (in_win) begin
            case (kind)
                K_READ:  allow = 1'b1;
                K_WRITE: allow = ok_w;
                K_FETCH: allow = !in_ip;
                default: allow = 1'b0;
            endcase
        end else begin
            allow = seg_ok && !(in_ip && master != M_CPU);
        end
    end
endmodule

// File: rtl/mrc_response.sv
// Registered response to refused accesses: one-cycle interrupt or reset
// pulse, sticky write-1-to-clear fault flags, and the read-data fill state.
module mrc_response
    import mrc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            viol,
    input  logic [SEGW-1:0] viol_seg,
    input  logic [NSEG-1:0] vsel,
    input  logic [NSEG-1:0] flag_clr,
    input  logic            rd_granted,
    output logic            nmi_pulse,
    output logic            rst_req,
    output logic [NSEG-1:0] flags,
    output logic            fill_on
);
    logic sel_rst;

    // Response type of the faulting segment
    always_comb begin
        sel_rst = 1'b0;
        for (int s = 0; s < NSEG; s++)
            if (viol_seg == SEGW'(s)) sel_rst = vsel[s];
    end

    // Pulse outputs, one cycle after the refusal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pulse <= 1'b0;
            rst_req   <= 1'b0;
        end else begin
            nmi_pulse <= viol && !sel_rst;
            rst_req   <= viol && sel_rst;
        end
    end

    // Sticky flags, one per segment; setting beats clearing
    for (genvar s = 0; s < NSEG; s++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                               flags[s] <= 1'b0;
            else if (viol && viol_seg == SEGW'(s))    flags[s] <= 1'b1;
            else if (flag_clr[s])                     flags[s] <= 1'b0;
        end
    end

    // Fill state: on after a refusal, off after next granted read or fetch
    always_ff @(posedge clk) begin
        if (!rst_n)          fill_on <= 1'b0;
        else if (viol)       fill_on <= 1'b1;
        else if (rd_granted) fill_on <= 1'b0;
    end
endmodule

// File: rtl/mem_rights_chk.sv
// Top of the memory access rights checker. Grants or refuses each access in
// the same cycle, gates memory strobes, and substitutes read data after a
// refusal. Assumes memory returns read data one cycle after mem_rd_en.
module mem_rights_chk
    import mrc_pkg::*;
#(
    parameter int          AW          = 16,
    parameter int          DW          = 16,
    parameter logic [15:0] VEC_BASE    = 16'hFF80,
    parameter logic [15:0] SUB_PATTERN = 16'h3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_master,
    input  logic [1:0]        acc_kind,
    input  logic [AW-1:0]     acc_addr,
    input  logic              mpu_en,
    input  logic [AW-1:0]     bnd_lo,
    input  logic [AW-1:0]     bnd_hi,
    input  logic [3*NSEG-1:0] seg_perm,
    input  logic [NSEG-1:0]   vsel,
    input  logic              ip_en,
    input  logic [AW-1:0]     ip_lo,
    input  logic [AW-1:0]     ip_hi,
    input  logic [NSEG-1:0]   flag_clr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              acc_grant,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic [DW-1:0]     rdata_out,
    output logic              nmi_pulse,
    output logic              rst_req,
    output logic [NSEG-1:0]   viol_flags
);
    logic [SEGW-1:0] seg_idx;
    logic            in_win, in_ip, allow, viol, fill_on;

    mrc_region_dec #(.AW(AW), .VEC_BASE(VEC_BASE)) u_dec (
        .addr    (acc_addr),
        .bnd_lo  (bnd_lo),
        .bnd_hi  (bnd_hi),
        .ip_en   (ip_en),
        .ip_lo   (ip_lo),
        .ip_hi   (ip_hi),
        .seg_idx (seg_idx),
        .in_win  (in_win),
        .in_ip   (in_ip)
    );

    mrc_rights u_rights (
        .master   (acc_master),
        .kind     (acc_kind),
        .seg_idx  (seg_idx),
        .in_win   (in_win),
        .in_ip    (in_ip),
        .mpu_en   (mpu_en),
        .seg_perm (seg_perm),
        .allow    (allow)
    );

    // Grant, refusal and memory strobes
    always_comb begin
        acc_grant = acc_valid && allow;
        viol      = acc_valid && !allow;
        mem_wr_en = acc_grant && (acc_kind == K_WRITE);
        mem_rd_en = acc_grant && (acc_kind == K_READ || acc_kind == K_FETCH);
    end

    mrc_response u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .viol       (viol),
        .viol_seg   (seg_idx),
        .vsel       (vsel),
        .flag_clr   (flag_clr),
        .rd_granted (mem_rd_en),
        .nmi_pulse  (nmi_pulse),
        .rst_req    (rst_req),
        .flags      (viol_flags),
        .fill_on    (fill_on)
    );

    // Read data seen by the master
    always_comb rdata_out = fill_on ? DW'(SUB_PATTERN) : mem_rdata;
endmodule

// File: rtl/mrc_chk.sv
// Assertion checker for mem_rights_chk, attached by bind below.
module mrc_chk
    import mrc_pkg::*;
#(
    parameter int          AW          = 16,
    parameter int          DW          = 16,
    parameter logic [15:0] VEC_BASE    = 16'hFF80,
    parameter logic [15:0] SUB_PATTERN = 16'h3FFF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [1:0]      acc_master,
    input logic [1:0]      acc_kind,
    input logic [AW-1:0]   acc_addr,
    input logic [NSEG-1:0] flag_clr,
    input logic            acc_grant,
    input logic            mem_wr_en,
    input logic            mem_rd_en,
    input logic [DW-1:0]   rdata_out,
    input logic            nmi_pulse,
    input logic            rst_req,
    input logic [NSEG-1:0] viol_flags
);
    a_r4_window_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_master != 2'd3 && acc_kind == 2'd0 &&
         acc_addr >= AW'(VEC_BASE)) |-> acc_grant);

    a_r8_no_strobe_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_grant) |-> (!mem_wr_en && !mem_rd_en));

    a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_pulse && rst_req));

    a_r9_pulse_after_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_grant) |=> (nmi_pulse || rst_req));

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pulse || rst_req) |-> $past(acc_valid && !acc_grant));

    a_r10_fill_after_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_grant) |=> (rdata_out == DW'(SUB_PATTERN)));

    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((viol_flags | $past(flag_clr)) & $past(viol_flags)) == $past(viol_flags)));
endmodule

bind mem_rights_chk mrc_chk #(
    .AW(AW), .DW(DW), .VEC_BASE(VEC_BASE), .SUB_PATTERN(SUB_PATTERN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_master (acc_master),
    .acc_kind   (acc_kind),
    .acc_addr   (acc_addr),
    .flag_clr   (flag_clr),
    .acc_grant  (acc_grant),
    .mem_wr_en  (mem_wr_en),
    .mem_rd_en  (mem_rd_en),
    .rdata_out  (rdata_out),
    .nmi_pulse  (nmi_pulse),
    .rst_req    (rst_req),
    .viol_flags (viol_flags)
);

// File: tb/tb_mem_rights_chk.sv
module tb_mem_rights_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_master = 2'd0;
    logic [1:0]  acc_kind = 2'd0;
    logic [15:0] acc_addr = 16'h0;
    logic        mpu_en = 1'b1;
    logic [15:0] bnd_lo = 16'h4000;
    logic [15:0] bnd_hi = 16'hC000;
    logic [8:0]  seg_perm = 9'b101_011_001;
    logic [2:0]  vsel = 3'b000;
    logic        ip_en = 1'b1;
    logic [15:0] ip_lo = 16'h8000;
    logic [15:0] ip_hi = 16'h8FFF;
    logic [2:0]  flag_clr = 3'b000;
    logic [15:0] mem_rdata = 16'h1234;
    logic        acc_grant, mem_wr_en, mem_rd_en, nmi_pulse, rst_req;
    logic [15:0] rdata_out;
    logic [2:0]  viol_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mem_rights_chk dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_master(acc_master),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .mpu_en(mpu_en), .bnd_lo(bnd_lo),
        .bnd_hi(bnd_hi), .seg_perm(seg_perm), .vsel(vsel), .ip_en(ip_en),
        .ip_lo(ip_lo), .ip_hi(ip_hi), .flag_clr(flag_clr), .mem_rdata(mem_rdata),
        .acc_grant(acc_grant), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
        .rdata_out(rdata_out), .nmi_pulse(nmi_pulse), .rst_req(rst_req),
        .viol_flags(viol_flags)
    );

    // {master, kind, addr, expected grant}; perms seg0 r, seg1 rw, seg2 rx
    localparam int NV = 20;
    localparam logic [20:0] VECS [NV] = '{
        {2'd0, 2'd0, 16'h1000, 1'b1},  // R1 seg0 read
        {2'd0, 2'd1, 16'h1000, 1'b0},  // R1 seg0 write
        {2'd0, 2'd2, 16'h1000, 1'b0},  // R1 seg0 fetch
        {2'd1, 2'd1, 16'h5000, 1'b1},  // R1 seg1 write by DMA
        {2'd0, 2'd2, 16'h5000, 1'b0},  // R1 seg1 fetch
        {2'd0, 2'd1, 16'h3FFF, 1'b0},  // R1 last seg0 address
        {2'd0, 2'd1, 16'h4000, 1'b1},  // R1 first seg1 address
        {2'd0, 2'd1, 16'hBFFF, 1'b1},  // R1 last seg1 address
        {2'd0, 2'd1, 16'hC000, 1'b0},  // R1 first seg2 address
        {2'd0, 2'd2, 16'hC000, 1'b1},  // R1 seg2 fetch
        {2'd1, 2'd0, 16'h8000, 1'b0},  // R3 DMA in IP window
        {2'd2, 2'd0, 16'h8FFF, 1'b0},  // R3 debug in IP window
        {2'd0, 2'd1, 16'h8100, 1'b1},  // R3 CPU in IP window
        {2'd1, 2'd0, 16'h9000, 1'b1},  // R3 DMA just past IP window
        {2'd1, 2'd0, 16'hFF80, 1'b1},  // R4 DMA window read
        {2'd0, 2'd1, 16'hFFFE, 1'b0},  // R5 window write, seg write off
        {2'd0, 2'd2, 16'hFFFE, 1'b1},  // R6 window fetch, no IP cover
        {2'd0, 2'd1, 16'h1000, 1'b0},  // R8 placeholder write (seg0)
        {2'd0, 2'd3, 16'h1000, 1'b0},  // R8 reserved kind
        {2'd3, 2'd0, 16'h1000, 1'b0}   // R8 reserved master
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive an access at the falling edge and sample the grant shortly after
    task automatic probe(input string req, input logic [1:0] m, input logic [1:0] k,
                         input logic [15:0] a, input logic exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_master = m; acc_kind = k; acc_addr = a;
        #1;
        check(req, {15'd0, acc_grant}, {15'd0, exp});
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; flag_clr = 3'b000;
    endtask

    task automatic after_edge();
        @(posedge clk); #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R12 reset state
        check("R12 nmi", {15'd0, nmi_pulse}, 16'd0);
        check("R12 rst_req", {15'd0, rst_req}, 16'd0);
        check("R12 flags", {13'd0, viol_flags}, 16'd0);
        check("R12 rdata", rdata_out, 16'h1234);

        // Table walk, also checks strobes (R8)
        for (int i = 0; i < NV; i++) begin
            logic [1:0] m, k; logic [15:0] a; logic e;
            {m, k, a, e} = VECS[i];
            probe("R1-table", m, k, a, e);
            check("R8 wr strobe", {15'd0, mem_wr_en}, {15'd0, e && k == 2'd1});
            check("R8 rd strobe", {15'd0, mem_rd_en}, {15'd0, e && (k == 2'd0 || k == 2'd2)});
        end
        idle();

        // R7 handler just below window, R4 read with read bit off
        seg_perm = 9'b000_011_001;
        probe("R7 fetch below window", 2'd0, 2'd2, 16'hFF7F, 1'b0);
        probe("R6 fetch in window", 2'd0, 2'd2, 16'hFF80, 1'b1);
        probe("R4 debug window read", 2'd2, 2'd0, 16'hFFFF, 1'b1);
        probe("R4 CPU below window", 2'd0, 2'd0, 16'hFF7F, 1'b0);

        // IP window covering the vector window
        ip_lo = 16'hFF00; ip_hi = 16'hFFFF;
        probe("R6 fetch under IP", 2'd0, 2'd2, 16'hFFC0, 1'b0);
        probe("R5 write seg bit off", 2'd1, 2'd1, 16'hFFC0, 1'b0);
        mpu_en = 1'b0;
        probe("R5 write only IP", 2'd1, 2'd1, 16'hFFC0, 1'b1);
        probe("R6 fetch IP no mpu", 2'd0, 2'd2, 16'hFFC0, 1'b0);
        probe("R2 seg0 write unchecked", 2'd0, 2'd1, 16'h1000, 1'b1);
        probe("R2 seg0 fetch unchecked", 2'd0, 2'd2, 16'h2000, 1'b1);
        mpu_en = 1'b1; seg_perm = 9'b101_011_001;
        ip_lo = 16'h8000; ip_hi = 16'h8FFF;
        idle();
        flag_clr = 3'b111; after_edge(); idle(); after_edge();

        // R9 interrupt pulse
        probe("R9 refuse", 2'd0, 2'd1, 16'h1000, 1'b0);
        after_edge();
        check("R9 nmi high", {15'd0, nmi_pulse}, 16'd1);
        check("R9 rst low", {15'd0, rst_req}, 16'd0);
        check("R10 fill", rdata_out, 16'h3FFF);
        check("R11 seg0 flag", {13'd0, viol_flags}, 16'd1);
        idle(); after_edge();
        check("R9 nmi single", {15'd0, nmi_pulse}, 16'd0);
        check("R10 fill held", rdata_out, 16'h3FFF);
        probe("R10 granted read", 2'd0, 2'd0, 16'h1000, 1'b1);
        after_edge();
        check("R10 fill released", rdata_out, 16'h1234);

        // R9 reset request selection
        vsel = 3'b001;
        probe("R9 refuse reset", 2'd0, 2'd1, 16'h1000, 1'b0);
        after_edge();
        check("R9 rst high", {15'd0, rst_req}, 16'd1);
        check("R9 nmi low", {15'd0, nmi_pulse}, 16'd0);
        idle(); after_edge();
        check("R9 rst single", {15'd0, rst_req}, 16'd0);
        vsel = 3'b000;

        // R11 flags: accumulate, clear, set beats clear
        probe("R11 refuse seg1", 2'd0, 2'd2, 16'h5000, 1'b0);
        after_edge();
        check("R11 two flags", {13'd0, viol_flags}, 16'd3);
        idle(); flag_clr = 3'b001; after_edge();
        check("R11 cleared seg0", {13'd0, viol_flags}, 16'd2);
        probe("R11 refuse seg1 again", 2'd0, 2'd2, 16'h5000, 1'b0);
        flag_clr = 3'b010;
        after_edge();
        check("R11 set beats clear", {13'd0, viol_flags}, 16'd2);
        idle(); flag_clr = 3'b010; after_edge();
        check("R11 cleared seg1", {13'd0, viol_flags}, 16'd0);
        idle(); after_edge();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule